// File: doc/BRIEF.md
# DMA Address Sequencing Engine

This block is the address half of one DMA channel. Software gives it a data size, a separate increment mode for the read side and for the write side, the address of the last item on each side, and an item count. After a start pulse it moves the items one at a time. Each item is one read of the chosen width from the source side, then one write of the same width to the destination side. The block then steps both addresses. It raises a one-cycle done pulse when the last write has been accepted.

Each side is described by its end pointer, not its start address. The engine works back from that pointer to find the first item. The increment on either side may be wider than the data size, so an 8-bit item can step by a full word. A side can also stay fixed. A fixed source with a byte-stepping destination is the usual way to empty an 8-bit peripheral data register into a buffer.

An illegal configuration is refused at start. The block then raises an error flag and makes no memory access. Memory is reached through one shared port with a request/grant handshake. Read data returns in the cycle after a read is granted. The item's bytes are moved from the source byte lanes to the destination byte lanes of the 32-bit bus.

Top module: `dma_addr_seq`

## Requirements
- R1: The size code is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. During a run, every request enables exactly 1, 2 or 4 byte lanes to match the size. Each item is one granted read followed by one granted write.
- R2: The step code of a side is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for no step. For N items, item k (counting from 0) on a stepping side uses the address end − (N−1−k)×step. Every address issued is naturally aligned to the size.
- R3: A side with step code 3 uses its end pointer for every item.
- R4: A step larger than the size is legal. An example is 8-bit items with a 4-byte source step and a 2-byte destination step.
- R5: A start is refused in four cases: the size code is 3, a stepping side's step code is below the size code, an end pointer is misaligned to the size, or the count is 0. A refused start raises err from the next cycle until the next legal start. It makes no memory request and gives no done pulse.
- R6: The read item is taken from the lanes selected by the source address bits [1:0]. It is written on mem_wdata at the lanes selected by the destination address bits [1:0], and all other wdata lanes are zero. mem_be marks the same lanes: 4'b0001, 4'b0011 or 4'b1111 shifted left by address bits [1:0].
- R7: done is high for exactly the one cycle after the final write is granted. In that cycle remaining reads 0 and busy is low.
- R8: A start pulse during a run is ignored. The addresses and data of the run in progress are unchanged.
- R9: While a request waits for grant, mem_addr, mem_we, mem_be and mem_wdata stay stable.
- R10: After a legal start, remaining reads the loaded count. It falls by one on each granted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| size | input | 2 | Data size code |
| src_inc | input | 2 | Source step code |
| dst_inc | input | 2 | Destination step code |
| src_end | input | ADDR_W | Address of the last source item |
| dst_end | input | ADDR_W | Address of the last destination item |
| count | input | CNT_W | Number of items |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final write |
| err | output | 1 | The last start was refused |
| remaining | output | CNT_W | Items not yet written |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a granted read |
| mem_gnt | input | 1 | Request accepted this cycle |

## Verification
The bench builds the block with ADDR_W = 16 and CNT_W = 6. With these values a bench memory of 256 bytes covers every address the runs produce, and counts up to 63 can be set. Source buffers sit in the lower half of that memory and destination buffers in the upper half. The expected write data therefore always comes straight from the bench memory's known initial contents. Runs alternate between a grant that is always high and a pseudo-random grant. This tests both back-to-back items and requests that wait for grant.

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [1:0]        src_inc,
  input  logic [1:0]        dst_inc,
  input  logic [ADDR_W-1:0] src_end,
  input  logic [ADDR_W-1:0] dst_end,
  input  logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  remaining,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_gnt
);

  localparam logic [1:0] STEP_NONE = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CAP, S_WR} state_t;

  state_t            state;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] src_q, dst_q, src_step_q, dst_step_q;
  logic [31:0]       item_q;
  logic [CNT_W-1:0]  rem_q;

  logic [1:0]        amask;
  logic              bad_size, bad_src, bad_dst, bad_align, bad_cnt, legal;
  logic [ADDR_W-1:0] cnt_m1, src_off, dst_off, src_step, dst_step;
  logic [31:0]       rd_shift, rd_item;
  logic [3:0]        lane_base;

  assign amask     = (size == 2'd0) ? 2'b00 : (size == 2'd1) ? 2'b01 : 2'b11;
  assign bad_size  = (size == 2'd3);
  assign bad_src   = (src_inc != STEP_NONE) && (src_inc < size);
  assign bad_dst   = (dst_inc != STEP_NONE) && (dst_inc < size);
  assign bad_align = ((src_end[1:0] & amask) != 2'b00) || ((dst_end[1:0] & amask) != 2'b00);
  assign bad_cnt   = (count == '0);
  assign legal     = !(bad_size || bad_src || bad_dst || bad_align || bad_cnt);

  assign cnt_m1   = ADDR_W'(count) - ADDR_W'(1);
  assign src_step = (src_inc == STEP_NONE) ? '0 : (ADDR_W'(1) << src_inc);
  assign dst_step = (dst_inc == STEP_NONE) ? '0 : (ADDR_W'(1) << dst_inc);
  assign src_off  = (src_inc == STEP_NONE) ? '0 : (cnt_m1 << src_inc);
  assign dst_off  = (dst_inc == STEP_NONE) ? '0 : (cnt_m1 << dst_inc);

  assign rd_shift = mem_rdata >> {src_q[1:0], 3'b000};
  assign rd_item  = (size_q == 2'd0) ? {24'd0, rd_shift[7:0]} :
                    (size_q == 2'd1) ? {16'd0, rd_shift[15:0]} : rd_shift;

  assign lane_base = (size_q == 2'd0) ? 4'b0001 : (size_q == 2'd1) ? 4'b0011 : 4'b1111;

  assign busy      = (state != S_IDLE);
  assign remaining = rem_q;
  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_WR) ? dst_q : src_q;
  assign mem_be    = !mem_req ? 4'b0000 :
                     4'(lane_base << ((state == S_WR) ? dst_q[1:0] : src_q[1:0]));
  assign mem_wdata = (state == S_WR) ? (item_q << {dst_q[1:0], 3'b000}) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      size_q     <= 2'd0;
      src_q      <= '0;
      dst_q      <= '0;
      src_step_q <= '0;
      dst_step_q <= '0;
      item_q     <= '0;
      rem_q      <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err <= !legal;
          if (legal) begin
            size_q     <= size;
            src_q      <= src_end - src_off;
            dst_q      <= dst_end - dst_off;
            src_step_q <= src_step;
            dst_step_q <= dst_step;
            rem_q      <= count;
            state      <= S_RD;
          end
        end
        S_RD: if (mem_gnt) state <= S_CAP;
        S_CAP: begin
          item_q <= rd_item;
          state  <= S_WR;
        end
        S_WR: if (mem_gnt) begin
          src_q <= src_q + src_step_q;
          dst_q <= dst_q + dst_step_q;
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [1:0] size_mask_q;
  assign size_mask_q = (size_q == 2'd0) ? 2'b00 : (size_q == 2'd1) ? 2'b01 : 2'b11;

  AST_LANES_MATCH_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_be) == (1 << size_q)) else $error("lane count"); // R1

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] & size_mask_q) == 2'b00) else $error("misaligned"); // R2

  AST_NO_ACCESS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req) else $error("access after refusal"); // R5

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_we && mem_gnt) && remaining == '0 && !busy) else $error("done"); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_be) && $stable(mem_wdata)) else $error("hold"); // R9

  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(mem_req && mem_we && mem_gnt) |=> $stable(remaining)) else $error("remaining"); // R10

endmodule

// File: tb/tb_dma_addr_seq.sv
module tb_dma_addr_seq;
  localparam int AW = 16;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] size = 0, src_inc = 0, dst_inc = 0;
  logic [AW-1:0] src_end = 0, dst_end = 0;
  logic [CW-1:0] count = 0;
  logic busy, done, err;
  logic [CW-1:0] remaining;
  logic mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  dma_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size), .src_inc(src_inc),
    .dst_inc(dst_inc), .src_end(src_end), .dst_end(dst_end), .count(count),
    .busy(busy), .done(done), .err(err), .remaining(remaining),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt));

  int checks = 0, errors = 0, accesses = 0, done_seen = 0;
  logic [7:0] mem [0:255];
  logic [7:0] lfsr = 8'h5A;
  logic stall_en = 0;
  logic [51:0] expq [$];
  logic exp_done = 0;

  function automatic logic [7:0] init_byte(int a);
    return 8'(a * 7 + 3);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
    mem_rdata = 0;
    mem_gnt = 1;
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      accesses <= accesses + 1;
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[{mem_addr[7:2], 2'(i)}] = mem_wdata[8*i +: 8];
      end else begin
        mem_rdata <= {mem[{mem_addr[7:2], 2'd3}], mem[{mem_addr[7:2], 2'd2}],
                      mem[{mem_addr[7:2], 2'd1}], mem[{mem_addr[7:2], 2'd0}]};
      end
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt <= stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_done) begin
        chk(done && remaining == 0 && !busy, "R7 done pulse", {done, busy, 6'(remaining)}, 8'h80);
        exp_done = 0;
      end else if (done) begin
        chk(0, "R7 unexpected done", 1, 0);
      end
      if (done) done_seen++;
      if (mem_req && mem_gnt && mem_we) begin
        if (expq.size() == 0) chk(0, "R2 unexpected write", mem_addr, 0);
        else begin
          logic [51:0] e;
          e = expq.pop_front();
          chk({mem_addr, mem_be, mem_wdata} == e, "R2 R6 write item", {mem_addr, mem_be, mem_wdata}, e);
          if (expq.size() == 0) exp_done = 1;
        end
      end
    end
  end

  task automatic pulse(input logic [1:0] sz, si, di, input logic [AW-1:0] se, de, input int n);
    @(negedge clk);
    size = sz; src_inc = si; dst_inc = di; src_end = se; dst_end = de; count = CW'(n);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run(input logic [1:0] sz, si, di, input logic [AW-1:0] se, de,
                     input int n, input bit poke, input string tag);
    int ss, ds, nb;
    ss = (si == 3) ? 0 : (1 << si);
    ds = (di == 3) ? 0 : (1 << di);
    nb = 1 << sz;
    for (int k = 0; k < n; k++) begin
      int sa, da;
      logic [31:0] item;
      logic [3:0] be;
      sa = int'(se) - (n - 1 - k) * ss;
      da = int'(de) - (n - 1 - k) * ds;
      item = 0;
      for (int b = 0; b < nb; b++) item[8*b +: 8] = init_byte(sa + b);
      be = 4'((nb == 1 ? 4'b0001 : nb == 2 ? 4'b0011 : 4'b1111) << da[1:0]);
      expq.push_back({16'(da), be, item << (8 * da[1:0])});
    end
    pulse(sz, si, di, se, de, n);
    chk(busy && remaining == CW'(n), "R10 loaded count", {busy, 6'(remaining)}, {1'b1, 6'(n)});
    if (poke) begin
      repeat (2) @(negedge clk);
      size = 2'd0; src_inc = 2'd3; dst_inc = 2'd3; src_end = 16'h0001; dst_end = 16'h00F1; count = 6'd9;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int w = 0; w < 3000 && (busy || expq.size() != 0); w++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0 && !busy, tag, expq.size(), 0);
  endtask

  task automatic run_bad(input logic [1:0] sz, si, di, input logic [AW-1:0] se, de,
                         input int n, input string tag);
    int a0, d0;
    a0 = accesses; d0 = done_seen;
    pulse(sz, si, di, se, de, n);
    chk(err == 1'b1 && !busy, {tag, " err"}, {err, busy}, 2'b10);
    repeat (8) @(negedge clk);
    chk(accesses == a0 && done_seen == d0 && !mem_req, {tag, " no access"}, accesses - a0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req && remaining == 0, "R7 reset state",
        {busy, done, err, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);

    run(2'd2, 2'd2, 2'd2, 16'h001C, 16'h009C, 4, 0, "R1 word copy");
    run(2'd0, 2'd3, 2'd0, 16'h0013, 16'h00A7, 8, 0, "R3 drain fixed source");
    run(2'd0, 2'd2, 2'd1, 16'h0031, 16'h00B9, 5, 0, "R4 wide stride byte");
    stall_en = 1;
    run(2'd1, 2'd1, 2'd2, 16'h0046, 16'h00C6, 3, 0, "R9 halfword stalls");
    run(2'd0, 2'd0, 2'd3, 16'h0052, 16'h00D3, 3, 0, "R3 fixed destination");
    run(2'd2, 2'd3, 2'd2, 16'h0060, 16'h00E0, 1, 0, "R2 single item");
    run(2'd1, 2'd2, 2'd1, 16'h0022, 16'h00F2, 6, 1, "R8 start while busy");
    stall_en = 0;
    run(2'd0, 2'd0, 2'd0, 16'h0010, 16'h0090, 17, 0, "R6 byte lanes run");

    run_bad(2'd3, 2'd2, 2'd2, 16'h0010, 16'h0090, 2, "R5 size code 3");
    run_bad(2'd2, 2'd0, 2'd2, 16'h0010, 16'h0090, 2, "R5 step below size");
    run_bad(2'd1, 2'd1, 2'd1, 16'h0011, 16'h0090, 2, "R5 misaligned end");
    run_bad(2'd0, 2'd0, 2'd0, 16'h0010, 16'h0090, 0, "R5 zero count");

    run(2'd1, 2'd1, 2'd1, 16'h0006, 16'h0086, 2, 0, "R5 legal start after refusal");
    chk(!err, "R5 err cleared", err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule